// File: doc/BRIEF.md
# Diagonal-Enable Crossbar Shifter

This block shifts or rotates a data word by a count of bit positions in a single pass. The core is a square switch matrix: every input bit has a switch to every output bit, and all switches that lie on one diagonal share a single enable line. A small decoder turns the operation code and the count into diagonal enables. Each output bit is the OR of the input bits whose switches are on, so an output that no enabled switch reaches reads as zero. Rotation turns on two complementary diagonals, and a separate sign-fill stage supplies sign extension for the arithmetic shift.

The datapath is combinational. A parameter selects whether the result is captured in an output register, which loads on a rising clock edge when `in_valid` is high and is cleared by a synchronous active-high reset.

Top module: `xbar_shifter`

## Requirements
- R1: With op = 2'b00 (logical left), `data_out` equals `data_in` shifted left by `shamt`, with zeros in the vacated low bits.
- R2: With op = 2'b01 (logical right), `data_out` equals `data_in` shifted right by `shamt`, with zeros in the vacated high bits.
- R3: With op = 2'b10 (arithmetic right), `data_out` equals `data_in` shifted right by `shamt`, with the `shamt` top bits equal to `data_in[7]`.
- R4: With op = 2'b11 (rotate right), bit i of `data_out` equals bit (i + shamt) mod 8 of `data_in`.
- R5: A count of 0 passes `data_in` through unchanged for every operation, and only the straight-through diagonal is enabled.
- R6: At most two diagonal enables are active at once, two only for a rotate with a nonzero count, so a rotate keeps the number of ones in the word.
- R7: Sign fill is applied only for the arithmetic shift with `data_in[7]` = 1; with a clear sign bit the arithmetic shift gives the same word as the logical right shift.
- R8: With the output register enabled, the result for inputs presented with `in_valid` high appears on `data_out` after the next rising edge, and `out_valid` is high in that cycle.
- R9: A cycle with `in_valid` low leaves `data_out` unchanged and drops `out_valid`.
- R10: A synchronous reset clears `data_out` to 0 and `out_valid` to 0 after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Loads the result into the output register |
| data_in | input | 8 | Word to shift or rotate |
| shamt | input | 3 | Shift or rotate count |
| op | input | 2 | Operation: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| data_out | output | 8 | Shifted word |
| out_valid | output | 1 | High when `data_out` holds a fresh result |

## Verification
A wrong diagonal enable shows as a displaced or missing bit in the very next registered result, so every count for every operation is driven over all 256 data words and each result is compared one cycle later. A rotate that also turns on a wrong diagonal, or a stray left diagonal at count 0, corrupts bits that a shift would zero, and changes the word's count of ones. Faulty fill logic shows only on arithmetic shifts of negative words, which the exhaustive sweep and the clear-sign comparison against logical right shift cover; register faults show as a missed load, a changed hold value or a nonzero word after reset.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    OP_LSL = 2'b00,
    OP_LSR = 2'b01,
    OP_ASR = 2'b10,
    OP_ROR = 2'b11
  } xbar_op_t;
endpackage

// File: rtl/xbar_diag_decode.sv
// Diagonal enable map: index 0 = straight, 1..W-1 = left k, W..2W-2 = right k (index W-1+k).
module xbar_diag_decode
  import xbar_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W),
  localparam int NDIAG = 2 * DATA_W - 1
) (
  input  xbar_op_t           op,
  input  logic [CNT_W-1:0]   cnt,
  output logic [NDIAG-1:0]   diag_en
);

  always_comb begin
    diag_en = '0;
    if (cnt == '0) begin
      diag_en[0] = 1'b1;
    end else begin
      unique case (op)
        OP_LSL: diag_en[int'(cnt)] = 1'b1;
        OP_LSR,
        OP_ASR: diag_en[DATA_W - 1 + int'(cnt)] = 1'b1;
        OP_ROR: begin
          diag_en[DATA_W - 1 + int'(cnt)] = 1'b1;
          diag_en[DATA_W - int'(cnt)]     = 1'b1;
        end
        default: diag_en = '0;
      endcase
    end
  end

  // R6: never more than two diagonals
  always_comb a_r6_two_max: assert ($countones(diag_en) <= 2);
  // R6: two diagonals only for a nonzero rotate
  always_comb a_r6_pair_ror: assert (($countones(diag_en) != 2) || (op == OP_ROR && cnt != '0));
  // R5: zero count drives only the straight diagonal
  always_comb a_r5_zero_straight: assert ((cnt != '0) || (diag_en == NDIAG'(1)));

endmodule

// File: rtl/xbar_matrix.sv
module xbar_matrix #(
  parameter int DATA_W = 8,
  localparam int NDIAG = 2 * DATA_W - 1
) (
  input  logic [DATA_W-1:0] din,
  input  logic [NDIAG-1:0]  diag_en,
  output logic [DATA_W-1:0] dout
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_row
    logic [DATA_W-1:0] sw;
    for (genvar j = 0; j < DATA_W; j++) begin : g_col
      localparam int IDX = (i == j) ? 0 :
                           (i > j)  ? (i - j) :
                                      (DATA_W - 1 + j - i);
      assign sw[j] = din[j] & diag_en[IDX];
    end
    assign dout[i] = |sw;
  end

endmodule

// File: rtl/xbar_sign_fill.sv
module xbar_sign_fill
  import xbar_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  xbar_op_t          op,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              sign,
  output logic [DATA_W-1:0] fill
);

  logic fill_on;
  assign fill_on = (op == OP_ASR) && sign;

  for (genvar i = 0; i < DATA_W; i++) begin : g_fill
    assign fill[i] = fill_on && (i >= DATA_W - int'(cnt));
  end

  // R7: fill bits appear only for an arithmetic shift of a negative word
  always_comb a_r7_fill_asr_only: assert ((fill == '0) || (op == OP_ASR && sign));

endmodule

// File: rtl/xbar_shifter.sv
module xbar_shifter
  import xbar_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int CNT_W  = $clog2(DATA_W),
  localparam int NDIAG  = 2 * DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CNT_W-1:0]  shamt,
  input  logic [1:0]        op,
  output logic [DATA_W-1:0] data_out,
  output logic              out_valid
);

  xbar_op_t          op_e;
  logic [NDIAG-1:0]  diag_en;
  logic [DATA_W-1:0] mat_out;
  logic [DATA_W-1:0] fill;
  logic [DATA_W-1:0] result;

  assign op_e = xbar_op_t'(op);

  xbar_diag_decode #(.DATA_W(DATA_W)) u_dec (
    .op      (op_e),
    .cnt     (shamt),
    .diag_en (diag_en)
  );

  xbar_matrix #(.DATA_W(DATA_W)) u_mat (
    .din     (data_in),
    .diag_en (diag_en),
    .dout    (mat_out)
  );

  xbar_sign_fill #(.DATA_W(DATA_W)) u_fill (
    .op   (op_e),
    .cnt  (shamt),
    .sign (data_in[DATA_W-1]),
    .fill (fill)
  );

  assign result = mat_out | fill;

  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              v;

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
        v <= 1'b0;
      end else begin
        v <= in_valid;
        if (in_valid) q <= result;
      end
    end

    assign data_out  = q;
    assign out_valid = v;

    // R8: a loaded cycle raises out_valid
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    // R4: a loaded rotate keeps the number of ones
    a_r4_rotate_ones: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_e == OP_ROR) |=> ($countones(data_out) == $countones($past(data_in))));
    // R9: an idle cycle holds the word and drops valid
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(data_out) && !out_valid));
    // R10: reset clears the register
    a_r10_reset_clear: assert property (@(posedge clk)
      rst |=> (data_out == '0 && !out_valid));
  end else begin : g_comb
    assign data_out  = result;
    assign out_valid = in_valid;
  end

endmodule

// File: tb/sim_xbar_shifter.sv
module sim_xbar_shifter;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] data_in = '0;
  logic [2:0] shamt = '0;
  logic [1:0] op = '0;
  logic [7:0] data_out;
  logic       out_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xbar_shifter #(.DATA_W(W), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .data_in(data_in),
    .shamt(shamt), .op(op), .data_out(data_out), .out_valid(out_valid)
  );

  function automatic logic [7:0] ref_shift(logic [7:0] d, logic [2:0] c, logic [1:0] o);
    logic [15:0] dd;
    dd = {d, d} >> c;
    case (o)
      2'b00:   return d << c;
      2'b01:   return d >> c;
      2'b10:   return 8'($signed(d) >>> c);
      default: return dd[7:0];
    endcase
  endfunction

  function automatic string op_tag(logic [1:0] o, logic [2:0] c);
    if (c == 0) return "R5";
    case (o)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(logic [7:0] d, logic [2:0] c, logic [1:0] o);
    @(negedge clk);
    data_in = d; shamt = c; op = o; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(logic [7:0] d, logic [2:0] c, logic [1:0] o);
    logic [7:0] e;
    e = ref_shift(d, c, o);
    load(d, c, o);
    check(op_tag(o, c), data_out, e);
    check("R8", {7'd0, out_valid}, 8'd1);
    if (o == 2'b11 && c != 0)
      check("R6", 8'($countones(data_out)), 8'($countones(d)));
    if (o == 2'b10 && !d[7])
      check("R7", data_out, d >> c);
  endtask

  initial begin
    logic [7:0] held;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R10: reset state
    check("R10", data_out, 8'h00);
    check("R10", {7'd0, out_valid}, 8'd0);
    rst = 1'b0;

    // directed corners
    run_one(8'b1001_1110, 3'd1, 2'b11);
    run_one(8'h80, 3'd7, 2'b10);
    run_one(8'h01, 3'd7, 2'b00);
    run_one(8'hA5, 3'd0, 2'b11);

    // exhaustive sweep over every op, count and data word
    for (int o = 0; o < 4; o++)
      for (int c = 0; c < 8; c++)
        for (int d = 0; d < 256; d++)
          run_one(8'(d), 3'(c), 2'(o));

    // R9: idle cycles hold the word while inputs wander
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 2) == 0) begin
        @(negedge clk);
        held = data_out;
        data_in = 8'($urandom); shamt = 3'($urandom); op = 2'($urandom);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9", data_out, held);
        check("R9", {7'd0, out_valid}, 8'd0);
      end else begin
        run_one(8'($urandom), 3'($urandom), 2'($urandom));
      end
    end

    // R10: reset after a nonzero load
    run_one(8'hFF, 3'd0, 2'b00);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10", data_out, 8'h00);
    check("R10", {7'd0, out_valid}, 8'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule